// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a memory-mapped countdown timer. Software loads a prescale limit and a starting count through a small word-addressed register bus. It then sets a start bit. While the timer runs, an internal prescale counter advances once per clock. Each time that counter reaches the prescale limit, it restarts and the count drops by one. When the count has reached zero, the timer returns to idle by itself.

The configuration is locked while the timer runs:

- The prescale limit cannot be rewritten.
- The count cannot be rewritten.
- A start request is honoured only when the timer is idle.
- A stop request is honoured only when the timer is running.

Reading the count register returns the live value while the timer runs. After a stop, the count keeps the value it had, so it can be read back and later resumed.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the status register (offset 1) reads 0, and the prescale (offset 2) and count (offset 3) registers read 0. Bit 0 of the status register is the running flag; its other bits read 0.
- R2: A write to the control register (offset 0) with bit 0 set, while the timer is idle, makes the running flag read 1 from the next cycle. It also restarts the prescale counter from zero.
- R3: A control write with bit 1 set stops a running timer, so the flag reads 0 from the next cycle. The same bit has no effect while idle. A start request (bit 0) while running has no effect on the flag, the count or the tick timing.
- R4: A write to the prescale register while the timer runs is ignored. The register keeps its value, and the tick period is unchanged.
- R5: While idle, a write to the count register sets the value read back from it. While running, such a write is ignored.
- R6: With prescale limit P, the count drops by exactly one every P+1 clocks. The first decrement becomes visible P+1 cycles after the start write's clock edge.
- R7: Once the count reads 0 while running, the running flag reads 0 from the next cycle, and the count stays at 0. Starting with a count of 0 gives exactly one cycle of running.
- R8: A stop leaves the current count in the count register. A later start resumes counting down from that value.
- R9: The control register always reads 0. Offsets 4 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; valid in the same cycle when cs=1 and we=0, otherwise 0 |

## Verification
The embedded assertions check the following on every cycle:

- the prescale counter never passes the limit while running;
- the prescale value stays fixed while running;
- a blocked count write changes the count by no more than a normal decrement;
- a stop or an expiry clears the running flag on the next edge;
- outside a tick, the count does not move.

Other behaviours can only be shown by the bench scenarios:

- the exact P+1-cycle tick spacing;
- resuming after a stop;
- the single running cycle of a zero-count start;
- a control word with both bits set, acting as start when idle and as stop when running;
- zero reads from unmapped offsets.

The bench compares these against its reference model on every clock.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int unsigned PTMR_W    = 32;
  localparam int unsigned REG_OFS_W = 2;

  typedef enum logic [REG_OFS_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_STATUS = 2'd1,
    REG_PSC    = 2'd2,
    REG_COUNT  = 2'd3
  } ptmr_reg_e;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;

  // A prescale period has elapsed when the counter sits on the limit.
  function automatic logic ptmr_tick(input logic [PTMR_W-1:0] pre,
                                     input logic [PTMR_W-1:0] limit);
    return pre == limit;
  endfunction

  function automatic logic [PTMR_W-1:0] ptmr_pre_next(input logic [PTMR_W-1:0] pre,
                                                      input logic [PTMR_W-1:0] limit);
    return ptmr_tick(pre, limit) ? '0 : pre + 1'b1;
  endfunction

  function automatic logic [PTMR_W-1:0] ptmr_count_dec(input logic [PTMR_W-1:0] cnt);
    return cnt - 1'b1;
  endfunction

endpackage

// File: rtl/ptmr_bus_dec.sv
module ptmr_bus_dec
  import ptmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output ptmr_reg_e         sel,
  output logic              wr_ctrl,
  output logic              wr_psc,
  output logic              wr_cnt,
  output logic              rd_en
);

  localparam int unsigned HI_W = ADDR_W - REG_OFS_W;

  generate
    if (HI_W > 0) begin : g_hi
      assign hit = (addr[ADDR_W-1:REG_OFS_W] == '0);
    end else begin : g_nohi
      assign hit = 1'b1;
    end
  endgenerate

  assign sel     = ptmr_reg_e'(addr[REG_OFS_W-1:0]);
  assign wr_ctrl = cs && we && hit && (sel == REG_CTRL);
  assign wr_psc  = cs && we && hit && (sel == REG_PSC);
  assign wr_cnt  = cs && we && hit && (sel == REG_COUNT);
  assign rd_en   = cs && !we && hit;

endmodule

// File: rtl/ptmr_cfg.sv
module ptmr_cfg
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_psc,
  input  logic [PTMR_W-1:0] wdata,
  input  logic              running,
  output logic [PTMR_W-1:0] psc
);

  logic psc_load_w;
  assign psc_load_w = wr_psc && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc <= '0;
    end else if (psc_load_w) begin
      psc <= wdata;
    end
  end

  AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(psc)); // R4

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              load_cnt,
  input  logic [PTMR_W-1:0] load_val,
  input  logic [PTMR_W-1:0] psc,
  output logic              running,
  output logic [PTMR_W-1:0] count
);

  logic [PTMR_W-1:0] pre_q;
  logic              tick_w;
  logic              expire_w;
  logic              stop_acc_w;
  logic              start_acc_w;

  assign expire_w    = running && (count == '0);
  assign tick_w      = running && (count != '0) && ptmr_tick(pre_q, psc);
  assign stop_acc_w  = running && stop_req;
  assign start_acc_w = !running && start_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre_q   <= '0;
      count   <= '0;
    end else if (running) begin
      if (stop_acc_w || expire_w) begin
        running <= 1'b0;
      end else begin
        pre_q <= ptmr_pre_next(pre_q, psc);
        if (tick_w) count <= ptmr_count_dec(count);
      end
    end else begin
      if (load_cnt) count <= load_val;
      if (start_acc_w) begin
        running <= 1'b1;
        pre_q   <= '0;
      end
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pre_q <= psc)); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick_w) |=> $stable(count)); // R6
  AST_STOP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_acc_w |=> !running); // R3
  AST_STOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_acc_w |=> $stable(count)); // R8
  AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (!running && count == '0)); // R7
  AST_CNT_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && load_cnt) |=> (count == $past(count) || count == $past(count) - 1'b1)); // R5
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(start_req)); // R2

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PTMR_W-1:0] wdata,
  output logic [PTMR_W-1:0] rdata
);

  logic              hit;
  ptmr_reg_e         sel;
  logic              wr_ctrl;
  logic              wr_psc;
  logic              wr_cnt;
  logic              rd_en;
  logic              running;
  logic [PTMR_W-1:0] psc;
  logic [PTMR_W-1:0] count;
  logic              start_req;
  logic              stop_req;

  ptmr_bus_dec #(.ADDR_W(ADDR_W)) dec_i (
    .cs      (cs),
    .we      (we),
    .addr    (addr),
    .hit     (hit),
    .sel     (sel),
    .wr_ctrl (wr_ctrl),
    .wr_psc  (wr_psc),
    .wr_cnt  (wr_cnt),
    .rd_en   (rd_en)
  );

  assign start_req = wr_ctrl && wdata[CTRL_START_BIT];
  assign stop_req  = wr_ctrl && wdata[CTRL_STOP_BIT];

  ptmr_cfg cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_psc  (wr_psc),
    .wdata   (wdata),
    .running (running),
    .psc     (psc)
  );

  ptmr_core core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .load_cnt  (wr_cnt),
    .load_val  (wdata),
    .psc       (psc),
    .running   (running),
    .count     (count)
  );

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      unique case (sel)
        REG_STATUS: rdata = {{(PTMR_W-1){1'b0}}, running};
        REG_PSC:    rdata = psc;
        REG_COUNT:  rdata = count;
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb_top;

  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;
  string       cur_req = "R1";

  // behavioural reference state
  bit          m_run;
  int unsigned m_pre, m_psc, m_cnt;
  bit          w_c, w_p, w_t;

  prescaled_timer #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pre = 0; m_psc = 0; m_cnt = 0;
    end else begin
      w_c = cs && we && addr == 0;
      w_p = cs && we && addr == 2;
      w_t = cs && we && addr == 3;
      if (m_run) begin
        if (w_c && wdata[1]) m_run = 0;
        else if (m_cnt == 0) m_run = 0;
        else if (m_pre == m_psc) begin m_pre = 0; m_cnt = m_cnt - 1; end
        else m_pre = m_pre + 1;
      end else begin
        if (w_p) m_psc = wdata;
        if (w_t) m_cnt = wdata;
        if (w_c && wdata[0]) begin m_run = 1; m_pre = 0; end
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    case (a)
      4'd1:    return {31'd0, m_run};
      4'd2:    return m_psc;
      4'd3:    return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  task automatic bus(input logic c, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] exp;
    cs = c; we = w; addr = a; wdata = d;
    #1;
    if (c && !w) begin
      exp = model_read(a);
      n_vec++;
      if (rdata !== exp) begin
        n_bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", cur_req, a, rdata, exp);
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus(1'b1, 1'b1, a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bus(1'b1, 1'b0, a, 32'd0);
  endtask

  // every idle cycle reads status or count and compares with the model
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) rd((i % 2 == 0) ? 4'd1 : 4'd3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";  rd(1); rd(2); rd(3);
    cur_req = "R9";  rd(0); rd(4); rd(7); rd(15);
    wr(5, 32'hFFFF); wr(9, 32'h1); idle(2);
    cur_req = "R5";  wr(3, 5); wr(2, 2); rd(3); rd(2);
    cur_req = "R6";  wr(0, 1); idle(25);          // R2 start, R7 expiry
    cur_req = "R4";  wr(3, 10); wr(2, 1); wr(0, 1); idle(3);
    wr(2, 7); rd(2); idle(2);
    cur_req = "R5";  wr(3, 99); rd(3); idle(2);
    cur_req = "R3";  wr(0, 1); idle(3); wr(0, 2); idle(3);
    cur_req = "R8";  rd(3); idle(4); wr(0, 1); idle(24);
    cur_req = "R3";  wr(0, 2); idle(3);
    cur_req = "R7";  wr(3, 0); wr(0, 1); idle(4);
    cur_req = "R6";  wr(3, 4); wr(2, 0); wr(0, 1); idle(8);
    cur_req = "R2";  wr(3, 3); wr(0, 3); idle(6);
    cur_req = "R3";  wr(3, 6); wr(2, 3); wr(0, 1); idle(5); wr(0, 3); idle(4);
    cur_req = "R9";  rd(0); rd(12);
    cur_req = "R6";  wr(3, 300); wr(2, 0); wr(0, 1); idle(310);
    finish_run();
  end

endmodule